// File: doc/BRIEF.md
# Frame-Based Register Access Codec

This block sits between a fixed-format serial link and the slow-control side of a front-end board. Each downlink frame has an 84-bit main word and a 32-bit side word. The block decodes one addressed transaction from each frame: a single-word read, or a burst of up to six 16-bit writes to consecutive addresses. It issues that transaction on one of three independent request/acknowledge register buses. When the transaction completes, it builds an uplink response frame of the same shape.

Only one transaction is in flight at a time. Frames that arrive while the block is busy are discarded and counted. Frames that name a bus that does not exist, or a word count that is not supported, are discarded and flagged. The serial transceiver, the bus masters behind the register ports and the remote registers all live outside this block.

Top module: `regframe_codec`

## Requirements
- R1: After reset, `up_valid`, `err_pulse` and every `rq_req` bit are 0, and `ovf_count` is 0.
- R2: A downlink frame is decoded as follows:
  - the 9-bit address comes from side bits 8:0;
  - the 3-bit count comes from side bits 11:9;
  - payload word 0 comes from side bits 31:16;
  - payload word k (k = 1..5) comes from main bits 16k-1:16(k-1).
  
  Side bits 15:12 and main bits 83:80 have no effect on the requests or on the response.
- R3: Address bits 8:7 select bus 0, 1 or 2, and only that bus's `rq_req` bit is raised. At most one `rq_req` bit is high at any time. Address bits 6:0 form the local register address.
- R4: A frame whose bus select is 3 causes no request and no response. It raises `err_pulse` for exactly one cycle.
- R5: Count 0 is a single read with `rq_we` = 0 at the local address. Its response carries the returned word in side bits 31:16 and zeros in main bits 79:0.
- R6: A count of 1 to 6 issues that many writes with `rq_we` = 1, in payload order starting with word 0. Each write goes to the next local address, and the local address wraps from 127 to 0 within the same bus.
- R7: A frame with count 7 causes no request and no response. It raises `err_pulse` for one cycle.
- R8: The response is emitted only after the last acknowledge, and its layout is:
  - main bits 83:82 = 0 and main bits 81:80 = 01;
  - side bits 8:0 echo the address, side bits 11:9 echo the count, and side bits 15:12 = 0;
  - for a write, side bits 31:16 hold word 0, and main word k holds payload word k when k is below the count and 0 otherwise.
- R9: A frame that arrives while a transaction is outstanding, up to and including its response cycle, is dropped. Each such frame increments `ovf_count`, which saturates at 255. `ovf_count` never changes in a cycle without `dn_valid`.
- R10: `up_valid` is high for exactly one cycle per accepted frame. A raised request holds its bus, address, direction and write data until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dn_valid | input | 1 | Downlink frame present this cycle |
| dn_main | input | 84 | Downlink main word |
| dn_side | input | 32 | Downlink side word |
| rq_req | output | 3 | Per-bus request, one-hot or zero |
| rq_we | output | 1 | 1 = write, 0 = read |
| rq_addr | output | 7 | Local register address |
| rq_wdata | output | 16 | Write data |
| rq_ack | input | 3 | Per-bus acknowledge, one cycle |
| rq_rdata | input | 48 | Read data, 16 bits per bus, bus 0 in the low bits |
| up_valid | output | 1 | Uplink response frame valid (one cycle) |
| up_main | output | 84 | Uplink main word |
| up_side | output | 32 | Uplink side word |
| err_pulse | output | 1 | One-cycle flag for a rejected frame |
| ovf_count | output | 8 | Saturating count of frames dropped while busy |

## Verification
The hardest state to reach from the ports is the saturated drop counter. It needs more than 255 frames to land while a single transaction stays outstanding. The bench's register responder can withhold its acknowledge indefinitely. With the acknowledge withheld, the bench holds `dn_valid` high for 300 cycles, checks the counter at 10 and at its ceiling, then releases the responder and confirms that the response belongs to the first frame. Burst wrap at local address 127 and the ignored frame fields are reached by directed frames and by seeded random traffic. The random traffic is confined to a narrow address window, so reads land on words written earlier.

// File: rtl/regframe_pkg.sv
package regframe_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_RESP} eng_state_t;
   localparam logic [1:0] CLASS_RESP = 2'd1;
endpackage

// File: rtl/regframe_parse.sv
module regframe_parse #(
   parameter int DW    = 16,
   parameter int AW    = 9,
   parameter int CW    = 3,
   parameter int SELW  = 2,
   parameter int NBUS  = 3,
   parameter int MAXW  = 6,
   parameter int MAINW = 84,
   parameter int SIDEW = 32
) (
   input  logic [MAINW-1:0]          main_i,
   input  logic [SIDEW-1:0]          side_i,
   output logic [AW-1:0]             addr_o,
   output logic [CW-1:0]             cnt_o,
   output logic [MAXW-1:0][DW-1:0]   words_o,
   output logic                      sel_bad_o,
   output logic                      cnt_bad_o
);
   localparam int HDRW = AW + CW;

   if (HDRW + DW > SIDEW) begin : g_bad_side
      $error("side word too narrow for header and first payload word");
   end
   if ((MAXW - 1) * DW + 4 > MAINW) begin : g_bad_main
      $error("main word too narrow for payload words");
   end

   assign addr_o    = side_i[AW-1:0];
   assign cnt_o     = side_i[HDRW-1:AW];
   assign words_o[0] = side_i[SIDEW-1 -: DW];

   for (genvar k = 1; k < MAXW; k++) begin : g_word
      assign words_o[k] = main_i[(k-1)*DW +: DW];
   end

   assign sel_bad_o = int'(addr_o[AW-1 -: SELW]) >= NBUS;
   assign cnt_bad_o = int'(cnt_o) > MAXW;
endmodule

// File: rtl/regframe_engine.sv
module regframe_engine
   import regframe_pkg::*;
#(
   parameter int DW   = 16,
   parameter int AW   = 9,
   parameter int CW   = 3,
   parameter int SELW = 2,
   parameter int NBUS = 3,
   parameter int MAXW = 6,
   localparam int LAW = AW - SELW
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start_i,
   input  logic [AW-1:0]             addr_i,
   input  logic [CW-1:0]             cnt_i,
   input  logic [MAXW-1:0][DW-1:0]   words_i,
   output logic                      busy_o,
   output logic                      done_o,
   output logic [NBUS-1:0]           rq_req_o,
   output logic                      rq_we_o,
   output logic [LAW-1:0]            rq_addr_o,
   output logic [DW-1:0]             rq_wdata_o,
   input  logic [NBUS-1:0]           rq_ack_i,
   input  logic [NBUS*DW-1:0]        rq_rdata_i,
   output logic [AW-1:0]             addr_q_o,
   output logic [CW-1:0]             cnt_q_o,
   output logic [MAXW-1:0][DW-1:0]   words_q_o,
   output logic [DW-1:0]             rdata_q_o
);
   if (LAW <= CW) begin : g_bad_law
      $error("local address must be wider than the word count");
   end

   eng_state_t              state_q;
   logic [CW-1:0]           idx_q;
   logic [AW-1:0]           addr_q;
   logic [CW-1:0]           cnt_q;
   logic [MAXW-1:0][DW-1:0] words_q;
   logic [DW-1:0]           rdata_q;
   logic [SELW-1:0]         bus_sel;
   logic [DW-1:0]           rd_sel;
   logic                    hit, is_wr, last;

   assign bus_sel = addr_q[AW-1 -: SELW];

   for (genvar b = 0; b < NBUS; b++) begin : g_bus
      assign rq_req_o[b] = (state_q == ST_XFER) && (bus_sel == SELW'(b));
   end

   always_comb begin
      rd_sel = '0;
      for (int b = 0; b < NBUS; b++) begin
         if (rq_req_o[b]) rd_sel = rq_rdata_i[b*DW +: DW];
      end
   end

   assign hit        = |(rq_req_o & rq_ack_i);
   assign is_wr      = (cnt_q != '0);
   assign last       = !is_wr || (idx_q == cnt_q - CW'(1));
   assign rq_we_o    = is_wr;
   assign rq_addr_o  = addr_q[LAW-1:0] + {{(LAW-CW){1'b0}}, idx_q};
   assign rq_wdata_o = words_q[idx_q];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         addr_q  <= '0;
         cnt_q   <= '0;
         words_q <= '0;
         rdata_q <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (start_i) begin
               addr_q  <= addr_i;
               cnt_q   <= cnt_i;
               words_q <= words_i;
               idx_q   <= '0;
               rdata_q <= '0;
               state_q <= ST_XFER;
            end
            ST_XFER: if (hit) begin
               if (!is_wr) rdata_q <= rd_sel;
               if (last) state_q <= ST_RESP;
               else      idx_q   <= idx_q + CW'(1);
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o    = (state_q != ST_IDLE);
   assign done_o    = (state_q == ST_RESP);
   assign addr_q_o  = addr_q;
   assign cnt_q_o   = cnt_q;
   assign words_q_o = words_q;
   assign rdata_q_o = rdata_q;
endmodule

// File: rtl/regframe_pack.sv
module regframe_pack
   import regframe_pkg::*;
#(
   parameter int DW    = 16,
   parameter int AW    = 9,
   parameter int CW    = 3,
   parameter int MAXW  = 6,
   parameter int MAINW = 84,
   parameter int SIDEW = 32
) (
   input  logic                      done_i,
   input  logic [AW-1:0]             addr_i,
   input  logic [CW-1:0]             cnt_i,
   input  logic [MAXW-1:0][DW-1:0]   words_i,
   input  logic [DW-1:0]             rdata_i,
   output logic                      up_valid_o,
   output logic [MAINW-1:0]          up_main_o,
   output logic [SIDEW-1:0]          up_side_o
);
   always_comb begin
      up_main_o = '0;
      up_side_o = '0;
      up_main_o[MAINW-3 -: 2] = CLASS_RESP;
      up_side_o[AW-1:0]       = addr_i;
      up_side_o[AW+CW-1:AW]   = cnt_i;
      up_side_o[SIDEW-1 -: DW] = (cnt_i == '0) ? rdata_i : words_i[0];
      for (int k = 1; k < MAXW; k++) begin
         if (int'(cnt_i) > k) up_main_o[(k-1)*DW +: DW] = words_i[k];
      end
   end

   assign up_valid_o = done_i;
endmodule

// File: rtl/regframe_codec.sv
module regframe_codec #(
   parameter int DW    = 16,
   parameter int AW    = 9,
   parameter int CW    = 3,
   parameter int SELW  = 2,
   parameter int NBUS  = 3,
   parameter int MAXW  = 6,
   parameter int MAINW = 84,
   parameter int SIDEW = 32,
   parameter int OVFW  = 8,
   localparam int LAW  = AW - SELW
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 dn_valid,
   input  logic [MAINW-1:0]     dn_main,
   input  logic [SIDEW-1:0]     dn_side,
   output logic [NBUS-1:0]      rq_req,
   output logic                 rq_we,
   output logic [LAW-1:0]       rq_addr,
   output logic [DW-1:0]        rq_wdata,
   input  logic [NBUS-1:0]      rq_ack,
   input  logic [NBUS*DW-1:0]   rq_rdata,
   output logic                 up_valid,
   output logic [MAINW-1:0]     up_main,
   output logic [SIDEW-1:0]     up_side,
   output logic                 err_pulse,
   output logic [OVFW-1:0]      ovf_count
);
   if (NBUS >= (1 << SELW)) begin : g_bad_nbus
      $error("bus count must leave one select value unused");
   end
   if (MAXW >= (1 << CW)) begin : g_bad_maxw
      $error("word count field cannot encode the rejected value");
   end

   logic [AW-1:0]           p_addr, e_addr;
   logic [CW-1:0]           p_cnt, e_cnt;
   logic [MAXW-1:0][DW-1:0] p_words, e_words;
   logic [DW-1:0]           e_rdata;
   logic                    sel_bad, cnt_bad, busy, done, accept, reject;
   logic                    err_q;
   logic [OVFW-1:0]         ovf_q;

   regframe_parse #(.DW(DW), .AW(AW), .CW(CW), .SELW(SELW), .NBUS(NBUS),
                    .MAXW(MAXW), .MAINW(MAINW), .SIDEW(SIDEW)) u_parse (
      .main_i(dn_main), .side_i(dn_side), .addr_o(p_addr), .cnt_o(p_cnt),
      .words_o(p_words), .sel_bad_o(sel_bad), .cnt_bad_o(cnt_bad));

   assign accept = dn_valid && !busy && !sel_bad && !cnt_bad;
   assign reject = dn_valid && !busy && (sel_bad || cnt_bad);

   regframe_engine #(.DW(DW), .AW(AW), .CW(CW), .SELW(SELW), .NBUS(NBUS),
                     .MAXW(MAXW)) u_engine (
      .clk(clk), .rst_n(rst_n), .start_i(accept), .addr_i(p_addr),
      .cnt_i(p_cnt), .words_i(p_words), .busy_o(busy), .done_o(done),
      .rq_req_o(rq_req), .rq_we_o(rq_we), .rq_addr_o(rq_addr),
      .rq_wdata_o(rq_wdata), .rq_ack_i(rq_ack), .rq_rdata_i(rq_rdata),
      .addr_q_o(e_addr), .cnt_q_o(e_cnt), .words_q_o(e_words),
      .rdata_q_o(e_rdata));

   regframe_pack #(.DW(DW), .AW(AW), .CW(CW), .MAXW(MAXW), .MAINW(MAINW),
                   .SIDEW(SIDEW)) u_pack (
      .done_i(done), .addr_i(e_addr), .cnt_i(e_cnt), .words_i(e_words),
      .rdata_i(e_rdata), .up_valid_o(up_valid), .up_main_o(up_main),
      .up_side_o(up_side));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_q <= 1'b0;
         ovf_q <= '0;
      end else begin
         err_q <= reject;
         if (dn_valid && busy && (ovf_q != '1)) ovf_q <= ovf_q + OVFW'(1);
      end
   end

   assign err_pulse = err_q;
   assign ovf_count = ovf_q;
endmodule

// File: rtl/regframe_codec_chk.sv
module regframe_codec_chk #(
   parameter int NBUS  = 3,
   parameter int LAW   = 7,
   parameter int DW    = 16,
   parameter int MAINW = 84,
   parameter int OVFW  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dn_valid,
   input logic [NBUS-1:0]   rq_req,
   input logic              rq_we,
   input logic [LAW-1:0]    rq_addr,
   input logic [DW-1:0]     rq_wdata,
   input logic [NBUS-1:0]   rq_ack,
   input logic              up_valid,
   input logic [MAINW-1:0]  up_main,
   input logic              err_pulse,
   input logic [OVFW-1:0]   ovf_count
);
   // R3
   onehot_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rq_req));

   // R10
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((|rq_req) && !(|(rq_req & rq_ack))) |=>
         ($stable(rq_req) && $stable(rq_addr) && $stable(rq_we) && $stable(rq_wdata)));

   // R10
   up_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      up_valid |=> !up_valid);

   // R8
   resp_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
      up_valid |-> (up_main[MAINW-1 -: 4] == 4'b0001));

   // R8
   resp_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      up_valid |-> (rq_req == '0));

   // R4
   err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |-> ((rq_req == '0) && !up_valid));

   // R9
   ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dn_valid |=> $stable(ovf_count));

   // R9
   ovf_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&ovf_count) |=> (&ovf_count));
endmodule

bind regframe_codec regframe_codec_chk #(
   .NBUS(NBUS), .LAW(LAW), .DW(DW), .MAINW(MAINW), .OVFW(OVFW)) u_chk (
   .clk(clk), .rst_n(rst_n), .dn_valid(dn_valid), .rq_req(rq_req),
   .rq_we(rq_we), .rq_addr(rq_addr), .rq_wdata(rq_wdata), .rq_ack(rq_ack),
   .up_valid(up_valid), .up_main(up_main), .err_pulse(err_pulse),
   .ovf_count(ovf_count));

// File: tb/regframe_codec_bench.sv
module regframe_codec_bench;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         dn_valid = 1'b0;
   logic [83:0]  dn_main = '0;
   logic [31:0]  dn_side = '0;
   logic [2:0]   rq_req;
   logic         rq_we;
   logic [6:0]   rq_addr;
   logic [15:0]  rq_wdata;
   logic [2:0]   rq_ack = '0;
   logic [47:0]  rq_rdata = '0;
   logic         up_valid;
   logic [83:0]  up_main;
   logic [31:0]  up_side;
   logic         err_pulse;
   logic [7:0]   ovf_count;

   int checks = 0, errors = 0;
   int resp_n = 0, err_n = 0;
   logic [83:0] last_main;
   logic [31:0] last_side;

   logic [15:0] dev   [3][128];
   logic [15:0] model [3][128];
   int          exp_bus = -1;
   logic [6:0]  exp_base;
   logic        exp_we;
   logic [15:0] exp_words [6];
   int          acc_idx = 0;
   bit          stall = 1'b0;
   int          wait_cnt = 0;

   always #2 clk = ~clk;

   regframe_codec u_regframe_codec (
      .clk(clk), .rst_n(rst_n), .dn_valid(dn_valid), .dn_main(dn_main),
      .dn_side(dn_side), .rq_req(rq_req), .rq_we(rq_we), .rq_addr(rq_addr),
      .rq_wdata(rq_wdata), .rq_ack(rq_ack), .rq_rdata(rq_rdata),
      .up_valid(up_valid), .up_main(up_main), .up_side(up_side),
      .err_pulse(err_pulse), .ovf_count(ovf_count));

   task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                      input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // Register responder on the three buses.
   initial begin
      for (int b = 0; b < 3; b++)
         for (int a = 0; a < 128; a++) begin
            dev[b][a] = '0;
            model[b][a] = '0;
         end
      forever begin
         @(negedge clk);
         if (rq_ack != '0) rq_ack = '0;
         else if (rq_req != '0 && !stall) begin
            if (wait_cnt > 0) wait_cnt--;
            else begin
               int b;
               b = rq_req[0] ? 0 : (rq_req[1] ? 1 : 2);
               chk(b == exp_bus, "R3 bus", b, exp_bus);
               chk(rq_addr == 7'(exp_base + 7'(acc_idx)), "R6 address", rq_addr,
                   7'(exp_base + 7'(acc_idx)));
               chk(rq_we == exp_we, "R5 direction", rq_we, exp_we);
               if (rq_we) begin
                  if (acc_idx < 6)
                     chk(rq_wdata == exp_words[acc_idx], "R6 write data", rq_wdata,
                         exp_words[acc_idx]);
                  dev[b][rq_addr] = rq_wdata;
               end else begin
                  rq_rdata[b*16 +: 16] = dev[b][rq_addr];
               end
               acc_idx++;
               rq_ack = rq_req;
               wait_cnt = $urandom_range(0, 2);
            end
         end
      end
   end

   // Output monitor.
   initial begin
      forever begin
         @(negedge clk);
         if (up_valid) begin
            resp_n++;
            last_main = up_main;
            last_side = up_side;
         end
         if (err_pulse) err_n++;
      end
   end

   task automatic send_frame(input logic [83:0] m, input logic [31:0] s);
      @(negedge clk);
      dn_valid = 1'b1;
      dn_main  = m;
      dn_side  = s;
      @(negedge clk);
      dn_valid = 1'b0;
   endtask

   logic [83:0] pend_main;
   logic [31:0] pend_side;
   int          pend_cnt;

   task automatic start_txn(input int bus, input logic [6:0] loc, input int cnt,
                            input logic [15:0] w [6]);
      logic [3:0] junk_s, junk_m;
      logic [8:0] addr;
      junk_s = 4'($urandom);
      junk_m = 4'($urandom);
      addr = {2'(bus), loc};
      exp_bus  = bus;
      exp_base = loc;
      exp_we   = (cnt != 0);
      for (int i = 0; i < 6; i++) exp_words[i] = w[i];
      acc_idx  = 0;
      pend_cnt = cnt;
      pend_main = '0;
      pend_main[81:80] = 2'b01;
      pend_side = '0;
      pend_side[8:0]  = addr;
      pend_side[11:9] = 3'(cnt);
      if (cnt == 0) pend_side[31:16] = model[bus][loc];
      else begin
         pend_side[31:16] = w[0];
         for (int k = 1; k < 6; k++)
            if (cnt > k) pend_main[(k-1)*16 +: 16] = w[k];
         for (int i = 0; i < cnt; i++) model[bus][7'(loc + 7'(i))] = w[i];
      end
      send_frame({junk_m, w[5], w[4], w[3], w[2], w[1]},
                 {w[0], junk_s, 3'(cnt), addr});
   endtask

   task automatic finish_txn(input string tag);
      int n0, t;
      n0 = resp_n;
      t = 0;
      while (resp_n == n0 && t < 400) begin
         @(negedge clk);
         t++;
      end
      chk(resp_n == n0 + 1, "R8 response seen", resp_n, n0 + 1);
      chk(last_main == pend_main, {tag, " main"}, last_main, pend_main);
      chk(last_side == pend_side, {tag, " side"}, last_side, pend_side);
      chk(acc_idx == ((pend_cnt == 0) ? 1 : pend_cnt), "R6 access count", acc_idx,
          (pend_cnt == 0) ? 1 : pend_cnt);
      @(negedge clk);
      @(negedge clk);
      // R10: one response per accepted frame
      chk(resp_n == n0 + 1, "R10 single pulse", resp_n, n0 + 1);
      exp_bus = -1;
   endtask

   task automatic bad_frame(input logic [8:0] addr, input logic [2:0] cnt,
                            input string tag);
      int r0, e0;
      r0 = resp_n;
      e0 = err_n;
      exp_bus = -1;
      acc_idx = 0;
      send_frame({4'h0, 80'h1234_5678_9abc_def0_1111}, {16'hbeef, 4'h0, cnt, addr});
      repeat (6) @(negedge clk);
      chk(err_n == e0 + 1, {tag, " error pulse"}, err_n, e0 + 1);
      chk(resp_n == r0, {tag, " no response"}, resp_n, r0);
      chk(acc_idx == 0, {tag, " no request"}, acc_idx, 0);
   endtask

   initial begin
      logic [15:0] w [6];
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(up_valid == 1'b0, "R1 up_valid", up_valid, 0);
      chk(err_pulse == 1'b0, "R1 err_pulse", err_pulse, 0);
      chk(rq_req == '0, "R1 rq_req", rq_req, 0);
      chk(ovf_count == '0, "R1 ovf_count", ovf_count, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R6: six-word burst wrapping past local address 127 on bus 2
      for (int i = 0; i < 6; i++) w[i] = 16'hA000 + 16'(i);
      start_txn(2, 7'd125, 6, w);
      finish_txn("R8 wrap burst");
      // R5: read back the wrapped words
      for (int i = 0; i < 6; i++) begin
         logic [15:0] junk [6];
         for (int j = 0; j < 6; j++) junk[j] = 16'($urandom);
         start_txn(2, 7'(125 + i), 0, junk);
         finish_txn("R5 read back");
      end

      // R4: bus select 3
      bad_frame({2'b11, 7'd5}, 3'd1, "R4");
      // R7: count 7
      bad_frame({2'b00, 7'd5}, 3'd7, "R7");
      // R9: rejects do not touch the drop counter
      chk(ovf_count == '0, "R9 no drops yet", ovf_count, 0);

      // R9: flood while a transaction is held outstanding
      for (int i = 0; i < 6; i++) w[i] = 16'h5500 + 16'(i);
      stall = 1'b1;
      start_txn(1, 7'd40, 3, w);
      @(negedge clk);
      dn_valid = 1'b1;
      dn_side  = {16'h0, 4'h0, 3'd1, 2'b00, 7'd0};
      repeat (10) @(negedge clk);
      chk(ovf_count == 8'd10, "R9 drop count", ovf_count, 10);
      repeat (290) @(negedge clk);
      dn_valid = 1'b0;
      chk(ovf_count == 8'd255, "R9 saturation", ovf_count, 255);
      chk(resp_n == 7, "R8 no response while stalled", resp_n, 7);
      stall = 1'b0;
      finish_txn("R9 first frame kept");
      chk(ovf_count == 8'd255, "R9 held after flood", ovf_count, 255);

      // R2 R3 R5 R6 R8: seeded random traffic in a narrow window
      for (int n = 0; n < 60; n++) begin
         int bus, cnt;
         logic [6:0] loc;
         bus = $urandom_range(0, 2);
         cnt = $urandom_range(0, 6);
         loc = 7'($urandom_range(0, 12));
         for (int i = 0; i < 6; i++) w[i] = 16'($urandom);
         start_txn(bus, loc, cnt, w);
         finish_txn("R2 random");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule